// File: doc/BRIEF.md
# ADC Capture Range Monitor

This block is a built-in self-test checker for a converter input path. After a start pulse it takes a fixed number of signed samples from a stream that a valid strobe qualifies. During the capture it keeps the smallest and the largest sample seen. At the end it decides whether the converter and its link look alive by comparing the spread between those two extremes against a threshold.

A path that is stuck low, stuck high or frozen gives a spread of zero or close to zero, so it fails. This holds even when the strobe keeps toggling. A live signal with real variation passes. The block reports a one-cycle completion pulse, a pass flag and an 8-bit detail code that identifies the failure. Verdict and code stay unchanged until the next start.

Top module: `adc_range_monitor`

## Requirements
- R1: After reset, `done_o`, `pass_o` and `detail_o` are all zero, and the monitor is idle.
- R2: A capture takes exactly WINDOW (default 256) samples. A sample counts only on a cycle with `smp_valid_i` high while a capture runs. `done_o` is high for exactly one cycle, the cycle after the clock edge that takes the last sample.
- R3: The verdict passes only when the largest sample minus the smallest sample over the window is strictly greater than THRESH (default 10). A span of exactly 10 fails and a span of 11 passes. The first and last samples of the window both take part.
- R4: When `done_o` is high, `detail_o` is 8'hAD on a fail and 8'h00 on a pass.
- R5: A window of constant 0 samples fails with detail 8'hAD.
- R6: A window of constant 16'h7FFF samples fails with detail 8'hAD. So does a window of constant 16'h8000.
- R7: The span is computed one bit wider than the samples. A window that holds both -32768 and 32767 gives a span of 65535 and passes.
- R8: Once a capture has completed, valid samples have no effect until the next start. They raise no `done_o`, and they leave `pass_o` and `detail_o` unchanged.
- R9: A start pulse aborts any capture in progress and discards the samples taken so far. On the following cycle `pass_o` and `detail_o` read zero.
- R10: If start arrives in the same cycle as the sample that would complete the window, start wins: no `done_o` follows. The sample presented in a start cycle is never counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin (or restart) a capture window |
| smp_valid_i | input | 1 | Sample qualifier |
| smp_data_i | input | SAMPLE_W | Signed two's-complement sample |
| done_o | output | 1 | One-cycle pulse when the verdict is ready |
| pass_o | output | 1 | Verdict: spread exceeded threshold |
| detail_o | output | 8 | 8'hAD on fail, 8'h00 on pass or while cleared |

## Verification
Two things can fall in the same cycle: a new start pulse, and the valid sample that would close the window. The bench feeds 255 valid zeros and then drives start together with a valid full-scale sample. It then requires that no completion pulse appears. After that it requires exactly 256 further samples before `done_o` rises, and it requires a fail verdict, which shows that the full-scale sample from the start cycle was not counted. The other windows sweep constant, stepped, alternating and spike patterns, with and without invalid cycles that carry extreme junk. Each verdict is checked against a span the bench computes from the samples it drove.

// File: rtl/arm_pkg.sv
package arm_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_CAPT = 1'b1
  } arm_state_e;

  localparam logic [7:0] DETAIL_FAIL = 8'hAD;
  localparam logic [7:0] DETAIL_OK   = 8'h00;
endpackage

// File: rtl/arm_window_ctrl.sv
module arm_window_ctrl
  import arm_pkg::*;
#(
  parameter int WINDOW = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic valid_i,
  output logic capt_o,
  output logic take_o,
  output logic last_o,
  output logic done_o
);
  localparam int CNT_W = (WINDOW > 1) ? $clog2(WINDOW) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WINDOW - 1);

  arm_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             take_w;
  logic             last_w;

  // a sample counts only in capture, and never in a start cycle
  assign take_w = (state_q == ST_CAPT) && valid_i && !start_i;
  assign last_w = take_w && (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_w;
      if (start_i) begin
        state_q <= ST_CAPT;
        cnt_q   <= '0;
      end else if (last_w) begin
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else if (take_w) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign capt_o = (state_q == ST_CAPT);
  assign take_o = take_w;
  assign last_o = last_w;
  assign done_o = done_q;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R2
  done_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> ($past(valid_i) && state_q == ST_IDLE));

  // R10
  start_blocks_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!done_q && state_q == ST_CAPT));
endmodule

// File: rtl/arm_extreme_tracker.sv
module arm_extreme_tracker #(
  parameter int SAMPLE_W = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       take_i,
  input  logic signed [SAMPLE_W-1:0] data_i,
  output logic signed [SAMPLE_W-1:0] min_nxt_o,
  output logic signed [SAMPLE_W-1:0] max_nxt_o
);
  localparam logic signed [SAMPLE_W-1:0] MOST_POS = {1'b0, {(SAMPLE_W-1){1'b1}}};
  localparam logic signed [SAMPLE_W-1:0] MOST_NEG = {1'b1, {(SAMPLE_W-1){1'b0}}};

  function automatic logic signed [SAMPLE_W-1:0] lower_of(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b);
    return (b < a) ? b : a;
  endfunction

  function automatic logic signed [SAMPLE_W-1:0] upper_of(
    input logic signed [SAMPLE_W-1:0] a,
    input logic signed [SAMPLE_W-1:0] b);
    return (b > a) ? b : a;
  endfunction

  logic signed [SAMPLE_W-1:0] min_q;
  logic signed [SAMPLE_W-1:0] max_q;
  logic signed [SAMPLE_W-1:0] min_nxt;
  logic signed [SAMPLE_W-1:0] max_nxt;

  always_comb begin
    min_nxt = min_q;
    max_nxt = max_q;
    if (take_i) begin
      min_nxt = lower_of(min_q, data_i);
      max_nxt = upper_of(max_q, data_i);
    end
  end

  // seeds are inverted extremes so the first sample overwrites both
  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      min_q <= MOST_POS;
      max_q <= MOST_NEG;
    end else begin
      min_q <= min_nxt;
      max_q <= max_nxt;
    end
  end

  assign min_nxt_o = min_nxt;
  assign max_nxt_o = max_nxt;

  // R3
  bounds_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !clear_i) |=> (min_q <= $past(data_i) && max_q >= $past(data_i)));
endmodule

// File: rtl/arm_range_judge.sv
module arm_range_judge
  import arm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int THRESH   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clear_i,
  input  logic                       last_i,
  input  logic signed [SAMPLE_W-1:0] min_i,
  input  logic signed [SAMPLE_W-1:0] max_i,
  output logic                       pass_o,
  output logic [7:0]                 detail_o
);
  localparam int SPAN_W = SAMPLE_W + 1;
  localparam logic signed [SPAN_W-1:0] THR = SPAN_W'(THRESH);

  // widened by one bit, so a full-scale spread cannot wrap
  function automatic logic signed [SPAN_W-1:0] span_of(
    input logic signed [SAMPLE_W-1:0] hi,
    input logic signed [SAMPLE_W-1:0] lo);
    return {hi[SAMPLE_W-1], hi} - {lo[SAMPLE_W-1], lo};
  endfunction

  logic signed [SPAN_W-1:0] span_w;
  logic                     wide_w;
  logic                     pass_q;
  logic [7:0]               detail_q;

  assign span_w = span_of(max_i, min_i);
  assign wide_w = span_w > THR;

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i) begin
      pass_q   <= 1'b0;
      detail_q <= DETAIL_OK;
    end else if (last_i) begin
      pass_q   <= wide_w;
      detail_q <= wide_w ? DETAIL_OK : DETAIL_FAIL;
    end
  end

  assign pass_o   = pass_q;
  assign detail_o = detail_q;

  // R7
  span_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_i |-> !span_w[SPAN_W-1]);
endmodule

// File: rtl/adc_range_monitor.sv
module adc_range_monitor
  import arm_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int WINDOW   = 256,
  parameter int THRESH   = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  output logic                done_o,
  output logic                pass_o,
  output logic [7:0]          detail_o
);
  logic                       capt_w;
  logic                       take_w;
  logic                       last_w;
  logic signed [SAMPLE_W-1:0] smp_s;
  logic signed [SAMPLE_W-1:0] min_nxt_w;
  logic signed [SAMPLE_W-1:0] max_nxt_w;

  assign smp_s = $signed(smp_data_i);

  arm_window_ctrl #(.WINDOW(WINDOW)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .valid_i (smp_valid_i),
    .capt_o  (capt_w),
    .take_o  (take_w),
    .last_o  (last_w),
    .done_o  (done_o)
  );

  arm_extreme_tracker #(.SAMPLE_W(SAMPLE_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start_i),
    .take_i    (take_w),
    .data_i    (smp_s),
    .min_nxt_o (min_nxt_w),
    .max_nxt_o (max_nxt_w)
  );

  arm_range_judge #(.SAMPLE_W(SAMPLE_W), .THRESH(THRESH)) u_judge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .last_i   (last_w),
    .min_i    (min_nxt_w),
    .max_i    (max_nxt_w),
    .pass_o   (pass_o),
    .detail_o (detail_o)
  );

  // R4
  detail_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (detail_o == (pass_o ? DETAIL_OK : DETAIL_FAIL)));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!capt_w && !start_i) |=> ($stable(pass_o) && $stable(detail_o) && !done_o));

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (!pass_o && detail_o == DETAIL_OK));
endmodule

// File: tb/adc_range_monitor_bench.sv
`timescale 1ns/1ps
module adc_range_monitor_bench;
  localparam int W = 16;
  localparam int WIN = 256;
  localparam int THR = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic         smp_valid_i = 1'b0;
  logic [W-1:0] smp_data_i = '0;
  logic         done_o;
  logic         pass_o;
  logic [7:0]   detail_o;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  adc_range_monitor #(.SAMPLE_W(W), .WINDOW(WIN), .THRESH(THR)) u_adc_range_monitor (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .smp_valid_i(smp_valid_i),
    .smp_data_i(smp_data_i), .done_o(done_o), .pass_o(pass_o), .detail_o(detail_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int pat(input int mode, input int i);
    case (mode)
      0: return 0;
      1: return 32767;
      2: return -32768;
      3: return i;
      4: return (i % 11) - 5000;
      5: return (i % 12) + 300;
      6: return (i % 2 == 1) ? 32767 : -32768;
      7: return ((i * 75 + 74) % 65537) - 32768;
      8: return (i == WIN - 1) ? 11 : 0;
      9: return (i == 0) ? -11 : 0;
      10: return (i == WIN - 1) ? 10 : 0;
      default: return 1000 - i;
    endcase
  endfunction

  function automatic string req_of(input int mode);
    case (mode)
      0: return "R5";
      1, 2: return "R6";
      6: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic pulse_start();
    @(negedge clk);
    start_i = 1'b1; smp_valid_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    // R9 cleared after start
    check(pass_o == 1'b0 && detail_o == 8'h00, "R9", {detail_o, pass_o}, 0);
  endtask

  task automatic run_window(input int mode, input int gap);
    int mn = 32767;
    int mx = -32768;
    int early = 0;
    bit exp_pass;
    pulse_start();
    for (int i = 0; i < WIN; i++) begin
      int v = pat(mode, i);
      if (gap > 0 && (i % gap) == gap - 1) begin
        smp_valid_i = 1'b0;
        smp_data_i = (i % 2 == 1) ? 16'h7FFF : 16'h8000;
        @(negedge clk);
        if (done_o) early++;
      end
      smp_valid_i = 1'b1;
      smp_data_i = W'(v);
      if (v < mn) mn = v;
      if (v > mx) mx = v;
      @(negedge clk);
      if (i < WIN - 1 && done_o) early++;
    end
    smp_valid_i = 1'b0;
    exp_pass = (mx - mn) > THR;
    // R2 no early done, done in the cycle after the last sample
    check(early == 0, "R2", early, 0);
    check(done_o == 1'b1, "R2", done_o, 1);
    check(pass_o == exp_pass, req_of(mode), pass_o, exp_pass);
    // R4 detail code
    check(detail_o == (exp_pass ? 8'h00 : 8'hAD), "R4", detail_o, exp_pass ? 0 : 173);
    @(negedge clk);
    check(done_o == 1'b0, "R2", done_o, 0);
  endtask

  task automatic idle_noise();
    logic       p0 = pass_o;
    logic [7:0] d0 = detail_o;
    int errs = 0;
    for (int i = 0; i < 20; i++) begin
      smp_valid_i = 1'b1;
      smp_data_i = (i % 2 == 1) ? 16'h7FFF : 16'h8000;
      @(negedge clk);
      if (done_o || pass_o != p0 || detail_o != d0) errs++;
    end
    smp_valid_i = 1'b0;
    // R8 post-completion samples ignored
    check(errs == 0, "R8", errs, 0);
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done_o == 0 && pass_o == 0 && detail_o == 0, "R1", {detail_o, pass_o, done_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done_o == 0 && pass_o == 0 && detail_o == 0, "R1", {detail_o, pass_o, done_o}, 0);

    for (int m = 0; m < 12; m++) run_window(m, 0);
    run_window(0, 3);
    run_window(1, 3);
    run_window(3, 4);
    run_window(4, 5);

    run_window(3, 0);
    idle_noise();

    // R9 restart mid-capture discards earlier samples
    pulse_start();
    for (int i = 0; i < 100; i++) begin
      smp_valid_i = 1'b1; smp_data_i = W'(i * 300);
      @(negedge clk);
    end
    run_window(2, 0);

    // R10 start coincides with the completing sample
    begin
      int early = 0;
      pulse_start();
      for (int i = 0; i < WIN - 1; i++) begin
        smp_valid_i = 1'b1; smp_data_i = '0;
        @(negedge clk);
        if (done_o) early++;
      end
      start_i = 1'b1; smp_valid_i = 1'b1; smp_data_i = 16'h7FFF;
      @(negedge clk);
      start_i = 1'b0;
      check(done_o == 1'b0, "R10", done_o, 0);
      for (int i = 0; i < WIN - 1; i++) begin
        smp_valid_i = 1'b1; smp_data_i = '0;
        @(negedge clk);
        if (done_o) early++;
      end
      check(early == 0, "R10", early, 0);
      smp_valid_i = 1'b1; smp_data_i = '0;
      @(negedge clk);
      smp_valid_i = 1'b0;
      check(done_o == 1'b1, "R10", done_o, 1);
      check(pass_o == 1'b0 && detail_o == 8'hAD, "R10", detail_o, 173);
    end
    idle_noise();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule